// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date in packed BCD registers. A single-cycle tick pulse, once per second, advances the seconds field. Each field hands a carry to the next, up through the minutes, hours, date, month, two-digit year and century. A binary day-of-week field steps alongside the date. The carry chain settles in the cycle that carries the tick.

Software never touches the running counters directly. It writes bytes into a staging buffer through an indexed register port. A commit strobe then copies the whole staging buffer into the live counters, but only while the unlock input is high. Reads go through a snapshot buffer. A snapshot strobe copies all eight live fields at once, and the read port then returns bytes from that frozen copy. A multi-byte read therefore never mixes values from before and after a tick.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset every field reads 00h except the century field, which reads 20h. This holds for the staging buffer, the live counters and the snapshot.
- R2: Seconds and minutes count 00 to 59 and hours count 00 to 23, all in packed BCD. Each one returns to 00 and carries to the next field. Hour bit 7 is a stored 24-hour-mode flag that the count never changes.
- R3: The date field counts from 01 up to the length of the current month and then returns to 01, carrying into the month. Month lengths are:
  - 28 or 29 days for month 02h;
  - 30 days for months 04h, 06h, 09h and 11h;
  - 31 days for every other month.
  A year that is a nonzero multiple of 4 is a leap year. Year 00 is a leap year only when the century field is 20h. The month field counts 01 to 12 and returns to 01.
- R4: The year counts 00 to 99 in BCD. On the step from 99 to 00 the century field toggles: 19h becomes 20h and 20h becomes 19h.
- R5: The day-of-week field is binary 0 to 6. It steps by one on every date change and wraps from 6 to 0.
- R6: The register index selects the field as follows: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 century. A staging write keeps only each field's defined bits and clears the rest. The masks are 7Fh, 7Fh, BFh, 3Fh, 1Fh, FFh, 07h and 3Fh, in index order.
- R7: A commit with unlock high copies all eight staged bytes into the live counters at the next edge. A commit with unlock low has no effect.
- R8: When an accepted commit and a tick fall in the same cycle, the live counters take the staged values and that tick is dropped.
- R9: A snapshot strobe captures the live fields at its edge, and the read port shows that copy until the next snapshot. A tick in the same cycle as the snapshot is not part of the captured copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse that advances time by one second |
| wrEn | input | 1 | Writes wrData into the staging byte selected by regAddr |
| wrData | input | 8 | Byte to stage |
| unlock | input | 1 | Level that permits a commit to reach the live counters |
| commit | input | 1 | One-cycle strobe that loads the staged bytes into the counters |
| snapStart | input | 1 | One-cycle strobe that freezes all live fields into the snapshot |
| regAddr | input | 3 | Field index for staging writes and snapshot reads |
| rdData | output | 8 | Snapshot byte selected by regAddr |

## Verification
Each kind of result has its own arrival time:
- A staged byte lands one edge after wrEn.
- A commit or a tick changes the live counters one edge after the strobe.
- A snapshot becomes visible on rdData at the edge that samples snapStart.
- rdData follows a change of regAddr with no clock at all.

The bench drives every strobe for exactly one rising edge, from one falling edge to the next. It reads results only after a snapshot has been taken behind the event under test, changing regAddr and sampling a nanosecond later. Freeze checks put ticks between the snapshot and the reads. The expected value is then the model state from before those ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELDS = 8;
  localparam int BYTEW  = 8;
  localparam int IDXW   = $clog2(FIELDS);

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DATE  = 3;
  localparam int F_MONTH = 4;
  localparam int F_YEAR  = 5;
  localparam int F_DOW   = 6;
  localparam int F_CENT  = 7;

  typedef logic [BYTEW-1:0] byteT;
  typedef logic [FIELDS-1:0][BYTEW-1:0] calT;

  typedef struct packed {
    logic              load;
    logic              snap;
    logic              stageWe;
    logic [FIELDS-1:0] bump;
    logic [FIELDS-1:0] roll;
  } ctrlStrobeT;

  function automatic byteT fieldMask(int f);
    case (f)
      F_SEC, F_MIN: return 8'h7F;
      F_HOUR:       return 8'hBF;
      F_DATE:       return 8'h3F;
      F_MONTH:      return 8'h1F;
      F_DOW:        return 8'h07;
      F_CENT:       return 8'h3F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic byteT fieldReset(int f);
    return (f == F_CENT) ? 8'h20 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       tick,
  input  logic       commit,
  input  logic       unlock,
  input  logic       snapStart,
  input  logic       wrEn,
  input  calT        liveIn,
  output ctrlStrobeT stb
);
  function automatic logic isLeap(byteT yr, byteT cent);
    logic [3:0] tens, units;
    tens  = yr[7:4];
    units = yr[3:0];
    if (yr == 8'h00) return cent == 8'h20;
    if (!tens[0])    return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
    return (units == 4'd2) || (units == 4'd6);
  endfunction

  function automatic byteT monthLen(byteT mon, logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  logic advance, dayCarry;
  logic secTop, minTop, hourTop, dateTop, monTop, yearTop, dowTop;
  byteT lastDate;

  always_comb begin
    lastDate = monthLen(liveIn[F_MONTH], isLeap(liveIn[F_YEAR], liveIn[F_CENT]));
    secTop   = liveIn[F_SEC] >= 8'h59;
    minTop   = liveIn[F_MIN] >= 8'h59;
    hourTop  = {2'b00, liveIn[F_HOUR][5:0]} >= 8'h23;
    dateTop  = liveIn[F_DATE] >= lastDate;
    monTop   = liveIn[F_MONTH] >= 8'h12;
    yearTop  = liveIn[F_YEAR] >= 8'h99;
    dowTop   = liveIn[F_DOW] >= 8'd6;
  end

  always_comb begin
    stb         = '0;
    stb.load    = commit & unlock;
    stb.snap    = snapStart;
    stb.stageWe = wrEn;
    advance     = tick & ~stb.load;

    stb.bump[F_SEC]   = advance;
    stb.roll[F_SEC]   = advance & secTop;
    stb.bump[F_MIN]   = stb.roll[F_SEC];
    stb.roll[F_MIN]   = stb.bump[F_MIN] & minTop;
    stb.bump[F_HOUR]  = stb.roll[F_MIN];
    stb.roll[F_HOUR]  = stb.bump[F_HOUR] & hourTop;
    dayCarry          = stb.roll[F_HOUR];
    stb.bump[F_DATE]  = dayCarry;
    stb.roll[F_DATE]  = dayCarry & dateTop;
    stb.bump[F_DOW]   = dayCarry;
    stb.roll[F_DOW]   = dayCarry & dowTop;
    stb.bump[F_MONTH] = stb.roll[F_DATE];
    stb.roll[F_MONTH] = stb.bump[F_MONTH] & monTop;
    stb.bump[F_YEAR]  = stb.roll[F_MONTH];
    stb.roll[F_YEAR]  = stb.bump[F_YEAR] & yearTop;
    stb.bump[F_CENT]  = stb.roll[F_YEAR];
    stb.roll[F_CENT]  = stb.roll[F_YEAR];
  end
endmodule

// File: rtl/rtc_dp.sv
module rtc_dp
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobeT      stb,
  input  logic [IDXW-1:0] regAddr,
  input  byteT            wrData,
  output calT             liveOut,
  output byteT            rdData
);
  calT liveQ, stageQ, snapQ;

  function automatic byteT bcdStep(byteT v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic byteT nextValue(int f, byteT v, logic wrapIt);
    byteT t;
    case (f)
      F_HOUR: begin
        t = bcdStep({2'b00, v[5:0]});
        return wrapIt ? {v[7], 7'h00} : {v[7], 1'b0, t[5:0]};
      end
      F_DATE, F_MONTH: return wrapIt ? 8'h01 : bcdStep(v);
      F_DOW:           return wrapIt ? 8'h00 : v + 8'd1;
      F_CENT:          return (v == 8'h19) ? 8'h20 : 8'h19;
      default:         return wrapIt ? 8'h00 : bcdStep(v);
    endcase
  endfunction

  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    localparam byteT MASK = fieldMask(f);
    localparam byteT RSTV = fieldReset(f);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[f] <= RSTV;
      end else if (stb.stageWe && (regAddr == IDXW'(f))) begin
        stageQ[f] <= wrData & MASK;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveQ[f] <= RSTV;
      end else if (stb.load) begin
        liveQ[f] <= stageQ[f];
      end else if (stb.bump[f]) begin
        liveQ[f] <= nextValue(f, liveQ[f], stb.roll[f]);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        snapQ[f] <= RSTV;
      end else if (stb.snap) begin
        snapQ[f] <= liveQ[f];
      end
    end
  end

  assign liveOut = liveQ;
  assign rdData  = snapQ[regAddr];
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            wrEn,
  input  logic [7:0]      wrData,
  input  logic            unlock,
  input  logic            commit,
  input  logic            snapStart,
  input  logic [IDXW-1:0] regAddr,
  output logic [7:0]      rdData
);
  ctrlStrobeT stb;
  calT        liveBus;

  rtc_ctrl u_ctrl (
    .tick      (tick),
    .commit    (commit),
    .unlock    (unlock),
    .snapStart (snapStart),
    .wrEn      (wrEn),
    .liveIn    (liveBus),
    .stb       (stb)
  );

  rtc_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .regAddr (regAddr),
    .wrData  (wrData),
    .liveOut (liveBus),
    .rdData  (rdData)
  );
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            tick,
  input logic            commit,
  input logic            unlock,
  input logic            snapStart,
  input logic [IDXW-1:0] regAddr,
  input byteT            rdData,
  input calT             liveBus
);
  // R7
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !(commit && unlock)) |=> $stable(liveBus));

  // R2
  sec_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !(commit && unlock)) |=> (liveBus[F_SEC] != $past(liveBus[F_SEC])));

  // R5
  dow_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !(commit && unlock)) |=> (liveBus[F_DOW] <= 8'd6));

  // R9
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !snapStart |=> (!$stable(regAddr) || $stable(rdData)));

  // R6
  dow_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == IDXW'(F_DOW)) |-> (rdData[7:3] == 5'd0));

  // R6
  hour_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == IDXW'(F_HOUR)) |-> (rdData[6] == 1'b0));
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .commit    (commit),
  .unlock    (unlock),
  .snapStart (snapStart),
  .regAddr   (regAddr),
  .rdData    (rdData),
  .liveBus   (liveBus)
);

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0, wrEn = 1'b0, unlock = 1'b0, commit = 1'b0, snapStart = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] rdData;

  int checks = 0, failures = 0;
  logic [7:0] mdl [8];
  logic [7:0] held [8];

  always #10 clk = ~clk;

  bcd_rtc_core u_bcd_rtc_core (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrData(wrData),
    .unlock(unlock), .commit(commit), .snapStart(snapStart),
    .regAddr(regAddr), .rdData(rdData)
  );

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int daysOf(int mo, int yr, int cen);
    logic leap;
    leap = (yr == 0) ? (cen == 20) : (yr % 4 == 0);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelTick();
    int s, mi, h, d, mo, y, c, w;
    logic mode;
    s = b2i(mdl[0]); mi = b2i(mdl[1]); mode = mdl[2][7]; h = b2i(mdl[2] & 8'h3F);
    d = b2i(mdl[3]); mo = b2i(mdl[4]); y = b2i(mdl[5]); w = int'(mdl[6]); c = b2i(mdl[7]);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; w = (w >= 6) ? 0 : w + 1;
          if (d >= daysOf(mo, y, c)) begin
            d = 1; mo++;
            if (mo > 12) begin
              mo = 1; y++;
              if (y == 100) begin y = 0; c = (c == 19) ? 20 : 19; end
            end
          end else d++;
        end
      end
    end
    mdl[0] = i2b(s); mdl[1] = i2b(mi); mdl[2] = {mode, 7'(i2b(h))};
    mdl[3] = i2b(d); mdl[4] = i2b(mo); mdl[5] = i2b(y); mdl[6] = 8'(w); mdl[7] = i2b(c);
  endtask

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, got, exp);
    end
  endtask

  task automatic stage(int idx, logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; regAddr = 3'(idx); wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doCommit(logic unl, logic withTick);
    @(negedge clk); commit = 1'b1; unlock = unl; tick = withTick;
    @(negedge clk); commit = 1'b0; unlock = 1'b0; tick = 1'b0;
  endtask

  task automatic doTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      modelTick();
    end
  endtask

  task automatic doSnap(logic withTick);
    @(negedge clk); snapStart = 1'b1; tick = withTick;
    @(negedge clk); snapStart = 1'b0; tick = 1'b0;
  endtask

  task automatic readAll(string req, logic [7:0] exp [8]);
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a); #1;
      check(req, $sformatf("field%0d", a), rdData, exp[a]);
    end
  endtask

  task automatic loadAll(logic [7:0] v [8]);
    for (int a = 0; a < 8; a++) stage(a, v[a]);
    doCommit(1'b1, 1'b0);
    mdl = v;
  endtask

  task automatic setTime(int s, int mi, int h, int d, int mo, int y, int w, int c);
    logic [7:0] v [8];
    v[0] = i2b(s); v[1] = i2b(mi); v[2] = i2b(h); v[3] = i2b(d);
    v[4] = i2b(mo); v[5] = i2b(y); v[6] = 8'(w); v[7] = i2b(c);
    loadAll(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v [8];
    void'($urandom(32'h5EED_0417));
    for (int a = 0; a < 8; a++) mdl[a] = (a == 7) ? 8'h20 : 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state read straight from the snapshot, then via a fresh snapshot
    readAll("R1", mdl);
    doSnap(1'b0);
    readAll("R1", mdl);

    // R2 R3 R4 R5: full rollover at the end of the century 19 year 99
    setTime(59, 59, 23, 31, 12, 99, 6, 19);
    doTicks(1); doSnap(1'b0);
    readAll("R4", mdl);
    check("R4", "century", mdl[7], 8'h20);
    check("R5", "dow wrap", mdl[6], 8'h00);

    // R4: century 20 toggles back to 19
    setTime(59, 59, 23, 31, 12, 99, 2, 20);
    doTicks(1); doSnap(1'b0);
    readAll("R4", mdl);

    // R3: February, non-leap, leap, year 00 in both centuries
    setTime(59, 59, 23, 28, 2, 1, 0, 20); doTicks(1); doSnap(1'b0); readAll("R3", mdl);
    check("R3", "mar1", mdl[4], 8'h03);
    setTime(59, 59, 23, 28, 2, 4, 0, 20); doTicks(1); doSnap(1'b0); readAll("R3", mdl);
    check("R3", "feb29", mdl[3], 8'h29);
    setTime(59, 59, 23, 28, 2, 0, 0, 19); doTicks(1); doSnap(1'b0); readAll("R3", mdl);
    setTime(59, 59, 23, 28, 2, 0, 0, 20); doTicks(1); doSnap(1'b0); readAll("R3", mdl);
    setTime(59, 59, 23, 30, 4, 50, 3, 20); doTicks(1); doSnap(1'b0); readAll("R3", mdl);

    // R2: 24-hour mode flag survives the hour rollover
    v[0] = 8'h59; v[1] = 8'h59; v[2] = 8'hA3; v[3] = 8'h10; v[4] = 8'h06; v[5] = 8'h22; v[6] = 8'h01; v[7] = 8'h20;
    loadAll(v); doTicks(1); doSnap(1'b0); readAll("R2", mdl);
    check("R2", "hour mode", mdl[2], 8'h80);

    // R6: masking of each field
    for (int a = 0; a < 8; a++) v[a] = 8'hFF;
    loadAll(v); doSnap(1'b0);
    v[0] = 8'h7F; v[1] = 8'h7F; v[2] = 8'hBF; v[3] = 8'h3F; v[4] = 8'h1F; v[5] = 8'hFF; v[6] = 8'h07; v[7] = 8'h3F;
    readAll("R6", v);

    // R7: locked commit is ignored
    setTime(10, 20, 5, 15, 7, 33, 4, 20);
    for (int a = 0; a < 8; a++) stage(a, 8'h01);
    doCommit(1'b0, 1'b0); doSnap(1'b0);
    readAll("R7", mdl);

    // R8: commit and tick together: staged values win
    setTime(1, 2, 3, 4, 5, 6, 1, 19);
    stage(0, 8'h45);
    mdl[0] = 8'h45;
    doCommit(1'b1, 1'b1); doSnap(1'b0);
    readAll("R8", mdl);

    // R9: snapshot with tick excludes that tick, then stays frozen
    setTime(30, 0, 12, 1, 1, 10, 5, 20);
    held = mdl;
    doSnap(1'b1); modelTick();
    doTicks(5);
    readAll("R9", held);
    doSnap(1'b0);
    readAll("R9", mdl);

    // R2 R3 R5: random valid start points with random tick runs
    for (int it = 0; it < 40; it++) begin
      int mo, y, c;
      mo = 1 + int'($urandom % 12); y = int'($urandom % 100); c = ($urandom % 2) ? 20 : 19;
      setTime(int'($urandom % 60), 56 + int'($urandom % 4), 22 + int'($urandom % 2),
              daysOf(mo, y, c) - int'($urandom % 2), mo, y, int'($urandom % 7), c);
      doTicks(1 + int'($urandom % 400));
      doSnap(1'b0);
      readAll("R2", mdl);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule